// File: doc/BRIEF.md
# Two-Source Vectored Interrupt Controller

This block sits beside a small 8-bit processor core and decides when the core takes a timer interrupt. Software reads and writes one 8-bit control and status byte. The byte holds a master enable, one enable per timer source and one sticky request flag per timer source. A timer overflow pulse sets its source's flag. The flag stays set until the interrupt is taken or software clears it.

Requests are evaluated only on the core's once-per-instruction timing pulse. An overflow that lands between two pulses is therefore taken at the next pulse. When both sources are pending, timer 0 wins. An accepted request produces a one-cycle call pulse carrying a 12-bit vector. The same acceptance clears the master enable and the serviced flag. A return-from-interrupt strobe turns the master enable back on. A full call stack blocks acceptance, and so does a closed acknowledge window.

Top module: `irq_vec_ctrl`

## Requirements
- R1: While reset is active and after it ends, the status byte reads 0x00 and no call pulse is issued.
- R2: A software write stores bit 0 (master enable), bit 2 (timer-0 enable), bit 3 (timer-1 enable), bit 5 (timer-0 flag) and bit 6 (timer-1 flag). Bits 1, 4 and 7 always read 0.
- R3: An overflow pulse on a source sets that source's flag at the next edge. The flag stays set until it is cleared. If a software write lands in the same cycle as the overflow, the overflow wins.
- R4: A request is accepted only at a clock edge where the timing pulse is high. The call output is high for exactly the one cycle after that edge. A request that becomes pending between pulses is accepted at the next pulse.
- R5: Accepting timer 0 drives vector 0x008. Accepting timer 1 drives vector 0x00C.
- R6: When both sources are enabled and flagged, timer 0 is accepted first. The timer-1 flag is left pending.
- R7: Acceptance clears the master enable and the serviced source's flag. This holds even if a software write or a return strobe arrives in the same cycle.
- R8: A return-from-interrupt strobe sets the master enable at the next edge. A still-pending request is then accepted at the following timing pulse.
- R9: With the master enable at 0, no request is accepted and every flag keeps its value.
- R10: With the stack-full input high, or with the acknowledge window closed, no request is accepted at a timing pulse.
- R11: A source whose enable bit is 0 is never accepted, even while its flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr_en | input | 1 | Software write strobe for the status byte |
| cpu_wr_data | input | 8 | Software write data |
| csr_rdata | output | 8 | Status byte readback |
| tmr_ovf | input | 2 | Overflow pulses; bit 0 is timer 0, bit 1 is timer 1 |
| instr_tick | input | 1 | Once-per-instruction timing pulse |
| ack_window_open | input | 1 | Core can accept a call in this cycle |
| stack_full | input | 1 | Core call stack has no free entry |
| reti_strobe | input | 1 | Return-from-interrupt executed |
| call_req | output | 1 | One-cycle call request |
| call_vector | output | 12 | Call target address, valid with call_req |

## Verification
Several internal faults show at the ports one cycle after the timing pulse at which a decision is made. A wrong flag, enable or priority state appears as a missing call, an extra call or the wrong vector. A failure to clear the master enable or the serviced flag also shows up there: readback is wrong in the call cycle, and a later pulse is served again without a return. A lost pending flag shows only after the next return strobe and timing pulse, when the lower-priority call fails to appear.

// File: rtl/irq_pkg.sv
package irq_pkg;
  localparam int NUM_SRC   = 2;
  localparam int CSR_W     = 8;
  localparam int VEC_W     = 12;
  localparam int ME_BIT    = 0;
  localparam int EN_BASE   = 2;
  localparam int FLAG_BASE = 5;
  localparam int VEC_BASE  = 8;
  localparam int VEC_STEP  = 4;

  // Storage bits of the status byte; all others are read-as-zero.
  function automatic logic [CSR_W-1:0] wr_mask(input int nsrc);
    logic [CSR_W-1:0] m;
    m = '0;
    m[ME_BIT] = 1'b1;
    for (int i = 0; i < nsrc; i++) begin
      m[EN_BASE+i]   = 1'b1;
      m[FLAG_BASE+i] = 1'b1;
    end
    return m;
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input int idx);
    return VEC_W'(VEC_BASE + VEC_STEP * idx);
  endfunction
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/irq_csr.sv
module irq_csr
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [CSR_W-1:0] wr_data,
  input  logic [N-1:0]     ovf,
  input  logic             ack,
  input  logic [N-1:0]     ack_sel,
  input  logic             reti,
  output logic [CSR_W-1:0] csr_q
);
  localparam logic [CSR_W-1:0] MASK = wr_mask(N);

  logic [CSR_W-1:0] csr_d;
  logic             csr_ce;

  assign csr_ce = wr_en | reti | ack | (|ovf);

  always_comb begin
    csr_d = csr_q;
    if (wr_en) csr_d = wr_data & MASK;
    if (reti)  csr_d[ME_BIT] = 1'b1;
    if (ack)   csr_d[ME_BIT] = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (ack_sel[i]) csr_d[FLAG_BASE+i] = 1'b0;
      if (ovf[i])     csr_d[FLAG_BASE+i] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      csr_q <= '0;
    else if (csr_ce) csr_q <= csr_d;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_pkg::*;
#(
  parameter int N = NUM_SRC
) (
  input  logic             master_en,
  input  logic [N-1:0]     src_en,
  input  logic [N-1:0]     src_flag,
  input  logic             tick,
  input  logic             win_open,
  input  logic             stack_full,
  output logic             ack,
  output logic [N-1:0]     ack_sel,
  output logic [VEC_W-1:0] ack_vec
);
  logic [N-1:0] req;
  logic [N-1:0] grant;
  logic [N:0]   above;
  logic         gate;

  assign gate     = tick & win_open & ~stack_full & master_en;
  assign above[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_prio
    assign req[i]     = src_en[i] & src_flag[i];
    assign grant[i]   = req[i] & ~above[i];
    assign above[i+1] = above[i] | req[i];
  end

  assign ack     = gate & above[N];
  assign ack_sel = gate ? grant : '0;

  always_comb begin
    ack_vec = '0;
    for (int i = 0; i < N; i++)
      if (ack_sel[i]) ack_vec = ack_vec | vec_of(i);
  end
endmodule

// File: rtl/irq_call_out.sv
module irq_call_out
  import irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack,
  input  logic [VEC_W-1:0] ack_vec,
  output logic             call_req,
  output logic [VEC_W-1:0] call_vector
);
  logic             req_d;
  logic [VEC_W-1:0] vec_d;

  always_comb begin
    req_d = ack;
    vec_d = call_vector;
    if (ack) vec_d = ack_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      call_req    <= 1'b0;
      call_vector <= '0;
    end else begin
      call_req    <= req_d;
      call_vector <= vec_d;
    end
  end
endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cpu_wr_en,
  input  logic [CSR_W-1:0]     cpu_wr_data,
  output logic [CSR_W-1:0]     csr_rdata,
  input  logic [NUM_SRC-1:0]   tmr_ovf,
  input  logic                 instr_tick,
  input  logic                 ack_window_open,
  input  logic                 stack_full,
  input  logic                 reti_strobe,
  output logic                 call_req,
  output logic [VEC_W-1:0]     call_vector
);
  logic               rst_n_sync;
  logic [CSR_W-1:0]   csr_q;
  logic               ack;
  logic [NUM_SRC-1:0] ack_sel;
  logic [VEC_W-1:0]   ack_vec;
  logic [NUM_SRC-1:0] src_en;
  logic [NUM_SRC-1:0] src_flag;

  irq_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_sync)
  );

  irq_csr #(.N(NUM_SRC)) u_csr (
    .clk(clk), .rst_n(rst_n_sync), .wr_en(cpu_wr_en), .wr_data(cpu_wr_data),
    .ovf(tmr_ovf), .ack(ack), .ack_sel(ack_sel), .reti(reti_strobe),
    .csr_q(csr_q)
  );

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_fields
    assign src_en[i]   = csr_q[EN_BASE+i];
    assign src_flag[i] = csr_q[FLAG_BASE+i];
  end

  irq_arbiter #(.N(NUM_SRC)) u_arb (
    .master_en(csr_q[ME_BIT]), .src_en(src_en), .src_flag(src_flag),
    .tick(instr_tick), .win_open(ack_window_open), .stack_full(stack_full),
    .ack(ack), .ack_sel(ack_sel), .ack_vec(ack_vec)
  );

  irq_call_out u_out (
    .clk(clk), .rst_n(rst_n_sync), .ack(ack), .ack_vec(ack_vec),
    .call_req(call_req), .call_vector(call_vector)
  );

  assign csr_rdata = csr_q;
endmodule

// File: rtl/irq_vec_ctrl_chk.sv
module irq_vec_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        instr_tick,
  input logic        ack_window_open,
  input logic        stack_full,
  input logic        reti_strobe,
  input logic [1:0]  tmr_ovf,
  input logic [7:0]  csr_rdata,
  input logic        call_req,
  input logic [11:0] call_vector
);
  always @(negedge clk) begin
    if (!rst_n) begin
      assert_reset_quiet_R1: assert (csr_rdata == 8'h00 && !call_req);
    end
  end

  assert_reserved_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rdata[1] && !csr_rdata[4] && !csr_rdata[7]);
  assert_ovf0_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf[0] |=> csr_rdata[5]);
  assert_ovf1_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_ovf[1] |=> csr_rdata[6]);
  assert_single_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |=> !call_req);
  assert_only_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_tick |=> !call_req);
  assert_vector_legal_R5: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> (call_vector == 12'h008 || call_vector == 12'h00C));
  assert_timer0_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (call_req && $past(csr_rdata[5] && csr_rdata[2])) |-> call_vector == 12'h008);
  assert_me_cleared_R7: assert property (@(posedge clk) disable iff (!rst_n)
    call_req |-> !csr_rdata[0]);
  assert_reti_sets_me_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reti_strobe && !instr_tick) |=> csr_rdata[0]);
  assert_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_tick && !csr_rdata[0]) |=> !call_req);
  assert_blocked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_tick && (stack_full || !ack_window_open)) |=> !call_req);
  assert_src_disabled_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_tick && !(csr_rdata[2] && csr_rdata[5]) && !(csr_rdata[3] && csr_rdata[6]))
      |=> !call_req);
endmodule

bind irq_vec_ctrl irq_vec_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n_sync), .instr_tick(instr_tick),
  .ack_window_open(ack_window_open), .stack_full(stack_full),
  .reti_strobe(reti_strobe), .tmr_ovf(tmr_ovf), .csr_rdata(csr_rdata),
  .call_req(call_req), .call_vector(call_vector)
);

// File: tb/irq_vec_ctrl_tb.sv
`timescale 1ns/1ps
module irq_vec_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr_en = 1'b0;
  logic [7:0]  cpu_wr_data = 8'h00;
  logic [7:0]  csr_rdata;
  logic [1:0]  tmr_ovf = 2'b00;
  logic        instr_tick = 1'b0;
  logic        ack_window_open = 1'b1;
  logic        stack_full = 1'b0;
  logic        reti_strobe = 1'b0;
  logic        call_req;
  logic [11:0] call_vector;
  int          n_cmp = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  irq_vec_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_data(cpu_wr_data),
    .csr_rdata(csr_rdata), .tmr_ovf(tmr_ovf), .instr_tick(instr_tick),
    .ack_window_open(ack_window_open), .stack_full(stack_full),
    .reti_strobe(reti_strobe), .call_req(call_req), .call_vector(call_vector)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    cpu_wr_en = 1'b1; cpu_wr_data = d;
    @(negedge clk);
    cpu_wr_en = 1'b0;
  endtask

  task automatic pulse_tick(input logic sf, input logic win);
    stack_full = sf; ack_window_open = win; instr_tick = 1'b1;
    @(negedge clk);
    instr_tick = 1'b0; stack_full = 1'b0; ack_window_open = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 csr in reset", csr_rdata, 8'h00);
    chk("R1 call in reset", call_req, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 csr after reset", csr_rdata, 8'h00);
    chk("R1 call after reset", call_req, 1'b0);

    // Sweep: every status byte content x stack-full x window open.
    for (int c = 0; c < 128; c++) begin
      logic me, e0, e1, f0, f1, sf, win, ok, sel0;
      logic [7:0] exp_wr, exp_after;
      me = c[0]; e0 = c[1]; e1 = c[2]; f0 = c[3]; f1 = c[4]; sf = c[5]; win = c[6];
      exp_wr = {1'b0, f1, f0, 1'b0, e1, e0, 1'b0, me};
      ok   = win && !sf && me && ((e0 && f0) || (e1 && f1));
      sel0 = e0 && f0;
      exp_after = exp_wr;
      if (ok) begin
        exp_after[0] = 1'b0;
        if (sel0) exp_after[5] = 1'b0; else exp_after[6] = 1'b0;
      end
      wr({1'b1, f1, f0, 1'b1, e1, e0, 1'b1, me});
      chk("R2 readback", csr_rdata, exp_wr);
      pulse_tick(sf, win);
      chk("R4 R9 R10 R11 call decision", call_req, ok);
      if (ok) chk("R5 R6 vector", call_vector, sel0 ? 12'h008 : 12'h00C);
      chk("R7 R9 status after pulse", csr_rdata, exp_after);
      @(negedge clk);
      chk("R4 single cycle", call_req, 1'b0);
    end

    // R3: overflow sets flag; overflow beats a same-cycle write of 0.
    wr(8'h00);
    tmr_ovf = 2'b01; @(negedge clk); tmr_ovf = 2'b00;
    chk("R3 ovf0 sets flag", csr_rdata, 8'h20);
    repeat (3) @(negedge clk);
    chk("R3 flag sticky", csr_rdata, 8'h20);
    tmr_ovf = 2'b11; wr(8'h00); tmr_ovf = 2'b00;
    chk("R3 ovf wins over write", csr_rdata, 8'h60);

    // R4: request arriving between pulses is served at the next pulse.
    wr(8'h05);
    tmr_ovf = 2'b01; @(negedge clk); tmr_ovf = 2'b00;
    for (int k = 0; k < 3; k++) begin
      chk("R4 no call between pulses", call_req, 1'b0);
      @(negedge clk);
    end
    pulse_tick(1'b0, 1'b1);
    chk("R4 served at pulse", call_req, 1'b1);
    chk("R5 timer0 vector", call_vector, 12'h008);

    // R6/R8: both pending, timer 0 first, timer 1 after return.
    wr(8'h6D);
    pulse_tick(1'b0, 1'b1);
    chk("R6 first vector", call_vector, 12'h008);
    chk("R6 timer1 still pending", csr_rdata, 8'h4C);
    pulse_tick(1'b0, 1'b1);
    chk("R7 no second call without return", call_req, 1'b0);
    reti_strobe = 1'b1; @(negedge clk); reti_strobe = 1'b0;
    chk("R8 return sets master enable", csr_rdata, 8'h4D);
    pulse_tick(1'b0, 1'b1);
    chk("R8 pending served after return", call_req, 1'b1);
    chk("R5 timer1 vector", call_vector, 12'h00C);
    chk("R7 flag and enable cleared", csr_rdata, 8'h0C);

    // R7: acceptance beats a same-cycle return and write.
    wr(8'h25);
    reti_strobe = 1'b1; cpu_wr_en = 1'b1; cpu_wr_data = 8'h25;
    pulse_tick(1'b0, 1'b1);
    reti_strobe = 1'b0; cpu_wr_en = 1'b0;
    chk("R7 accepted despite return", call_req, 1'b1);
    chk("R7 ack wins over write and return", csr_rdata, 8'h04);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule